// File: doc/BRIEF.md
# Data path suspend controller

This block is the state machine of a card data path that carries out a suspend request on a transfer that is already running. The command side reports whether the command now being sent is a suspend, and when the card's response arrives it reports whether the card acknowledged it or the command timed out. Only an acknowledged suspend is recorded. Any other response leaves the transfer running as though no suspend had been sent.

On a write, an accepted suspend lets the block finish sending its current block. The data path goes idle when that block's CRC token comes back. On a read, the card first completes the packet in progress. The data path then holds in a receive-wait state until software has emptied the receive FIFO, and after that it goes idle without further action. Software can also end any transfer at once by clearing the data-path enable. The record of a pending suspend is dropped whenever the block is idle, so the next transfer starts without it. The block keeps no count of the blocks that remain for a later resume.

Top module: `dp_suspend_ctrl`

## Requirements
- R1: After reset `state` is 0 (idle) and `idle` is 1. The state encoding is 0 idle, 1 send, 2 receive, 3 receive-wait, and `idle` is 1 exactly when `state` is 0.
- R2: In idle, a `xfer_start` pulse while `dp_en` is 1 moves the state to send if `dir_rd` is 0 and to receive if `dir_rd` is 1, one clock later. With `dp_en` at 0 the pulse is ignored and the state stays idle.
- R3: In send, once a suspend has been accepted, a `crc_tok` pulse moves the state to idle on the next clock. Before that, the state stays in send until the token arrives. Without an accepted suspend, `crc_tok` leaves the state in send.
- R4: In any state other than idle, `dp_en` at 0 moves the state to idle on the next clock. This takes priority over every other event.
- R5: In receive, once a suspend has been accepted, `pkt_done` moves the state to receive-wait. The state stays in receive-wait while `rxfifo_empty` is 0 and moves to idle on the clock after `rxfifo_empty` is 1.
- R6: A suspend is accepted only when `rsp_valid` and `rsp_ack` are both 1, `cmd_susp` is 1 and `rsp_timeout` is 0. A negative response, a timeout, or an acknowledge to a command that is not a suspend records nothing, and a later `crc_tok` or `pkt_done` then leaves the state unchanged.
- R7: An accepted suspend is cleared once the block is idle. In the next transfer, `crc_tok` or `pkt_done` does not suspend unless a new suspend is accepted.
- R8: In send or receive, a `xfer_end` pulse moves the state to idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dp_en | input | 1 | Data-path enable; 0 aborts the transfer |
| xfer_start | input | 1 | Pulse that starts a transfer |
| dir_rd | input | 1 | Transfer direction: 1 read, 0 write |
| cmd_susp | input | 1 | The command being sent is a suspend |
| rsp_valid | input | 1 | A command response has been evaluated |
| rsp_ack | input | 1 | The response is an acknowledge |
| rsp_timeout | input | 1 | The command timed out |
| crc_tok | input | 1 | CRC token of the current write block received |
| pkt_done | input | 1 | Current read packet fully received |
| rxfifo_empty | input | 1 | Receive FIFO is empty |
| xfer_end | input | 1 | Normal end of the whole transfer |
| state | output | 2 | Data-path state (0 idle, 1 send, 2 receive, 3 receive-wait) |
| idle | output | 1 | Data path is idle |

## Verification
The assertions take for granted that every event input is a single-cycle pulse. They also assume that `crc_tok` comes only during writes and `pkt_done` only during reads, and that `rxfifo_empty` and `dp_en` hold steady between the cycles in which the bench changes them. The stimulus drives all inputs on the falling edge and clears every pulse after one cycle. It places suspend responses strictly inside an active transfer, and it changes the direction only while the block is idle.

// File: rtl/dp_suspend_ctrl.sv
module dp_suspend_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp_en,
  input  logic       xfer_start,
  input  logic       dir_rd,
  input  logic       cmd_susp,
  input  logic       rsp_valid,
  input  logic       rsp_ack,
  input  logic       rsp_timeout,
  input  logic       crc_tok,
  input  logic       pkt_done,
  input  logic       rxfifo_empty,
  input  logic       xfer_end,
  output logic [1:0] state,
  output logic       idle
);

  localparam logic [1:0] S_IDLE  = 2'd0;
  localparam logic [1:0] S_SEND  = 2'd1;
  localparam logic [1:0] S_RECV  = 2'd2;
  localparam logic [1:0] S_RWAIT = 2'd3;

  logic [1:0] cur, nxt;
  logic       pend, pend_nxt;
  logic       accept;
  logic       suspended;

  assign accept    = cmd_susp & rsp_valid & rsp_ack & ~rsp_timeout & (cur != S_IDLE);
  assign suspended = pend | accept;

  always_comb begin
    nxt = cur;
    case (cur)
      S_IDLE:  if (xfer_start && dp_en) nxt = dir_rd ? S_RECV : S_SEND;
      S_SEND: begin
        if (!dp_en)                    nxt = S_IDLE;
        else if (crc_tok && suspended) nxt = S_IDLE;
        else if (xfer_end)             nxt = S_IDLE;
      end
      S_RECV: begin
        if (!dp_en)                     nxt = S_IDLE;
        else if (pkt_done && suspended) nxt = S_RWAIT;
        else if (xfer_end)              nxt = S_IDLE;
      end
      default: if (!dp_en || rxfifo_empty) nxt = S_IDLE;
    endcase
  end

  assign pend_nxt = (nxt == S_IDLE) ? 1'b0 : suspended;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= S_IDLE;
      pend <= 1'b0;
    end else begin
      cur  <= nxt;
      pend <= pend_nxt;
    end
  end

  assign state = cur;
  assign idle  = (cur == S_IDLE);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle == (state == S_IDLE));

  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !(xfer_start && dp_en)) |=> state == S_IDLE);

  assert_wr_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SEND && dp_en && pend && crc_tok) |=> state == S_IDLE);

  assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !dp_en) |=> state == S_IDLE);

  assert_rwait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RWAIT && dp_en && !rxfifo_empty) |=> state == S_RWAIT);

  assert_rwait_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RWAIT && rxfifo_empty) |=> state == S_IDLE);

  assert_no_false_susp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SEND && dp_en && !pend && !(cmd_susp && rsp_valid && rsp_ack && !rsp_timeout)
     && !xfer_end) |=> state == S_SEND);

  assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !(xfer_start && dp_en)) |=> !pend);

  assert_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_SEND || state == S_RECV) && dp_en && xfer_end) |=> state != S_SEND && state != S_RECV);

endmodule

// File: tb/sim_dp_suspend_ctrl.sv
`timescale 1ns/1ps
module sim_dp_suspend_ctrl;
  logic clk = 0, rst_n = 0;
  logic dp_en = 0, xfer_start = 0, dir_rd = 0, cmd_susp = 0, rsp_valid = 0, rsp_ack = 0;
  logic rsp_timeout = 0, crc_tok = 0, pkt_done = 0, rxfifo_empty = 1, xfer_end = 0;
  logic [1:0] state;
  logic idle;
  int checks = 0, errors = 0;
  logic [1:0] expq[$];
  string tagq[$];
  bit done = 0;

  always #2 clk = ~clk;

  dp_suspend_ctrl u0 (.clk(clk), .rst_n(rst_n), .dp_en(dp_en), .xfer_start(xfer_start),
    .dir_rd(dir_rd), .cmd_susp(cmd_susp), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .rsp_timeout(rsp_timeout), .crc_tok(crc_tok), .pkt_done(pkt_done),
    .rxfifo_empty(rxfifo_empty), .xfer_end(xfer_end), .state(state), .idle(idle));

  task automatic step(input logic [1:0] exp, input string tag);
    expq.push_back(exp);
    tagq.push_back(tag);
    @(negedge clk);
    xfer_start = 0; cmd_susp = 0; rsp_valid = 0; rsp_ack = 0; rsp_timeout = 0;
    crc_tok = 0; pkt_done = 0; xfer_end = 0;
  endtask

  task automatic susp_rsp(input logic s, input logic a, input logic t);
    cmd_susp = s; rsp_valid = 1; rsp_ack = a; rsp_timeout = t;
  endtask

  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      logic [1:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      checks++;
      if (state !== e || idle !== (e == 2'd0)) begin
        errors++;
        $display("FAIL %s: state=%0d idle=%0b expected state=%0d idle=%0b", t, state, idle, e, e == 2'd0);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (state !== 2'd0 || idle !== 1'b1) begin
      errors++;
      $display("FAIL R1: state=%0d idle=%0b expected state=0 idle=1", state, idle);
    end
    rst_n = 1;
    @(negedge clk);
    // R1 held after reset release, R2 start gated by enable
    step(2'd0, "R1");
    xfer_start = 1; step(2'd0, "R2");
    dp_en = 1; dir_rd = 0; xfer_start = 1; step(2'd1, "R2");
    crc_tok = 1; step(2'd1, "R3");
    // R6 negative response, timeout, acknowledge to a non-suspend command
    susp_rsp(1, 0, 0); step(2'd1, "R6");
    crc_tok = 1; step(2'd1, "R6");
    susp_rsp(1, 1, 1); step(2'd1, "R6");
    crc_tok = 1; step(2'd1, "R6");
    susp_rsp(0, 1, 0); step(2'd1, "R6");
    crc_tok = 1; step(2'd1, "R6");
    // R3 accepted write suspend, finishes at CRC token
    susp_rsp(1, 1, 0); step(2'd1, "R3");
    step(2'd1, "R3");
    crc_tok = 1; step(2'd0, "R3");
    // R7 fresh write after suspend
    xfer_start = 1; step(2'd1, "R7");
    crc_tok = 1; step(2'd1, "R7");
    xfer_end = 1; step(2'd0, "R8");
    // R5 read suspend
    dir_rd = 1; xfer_start = 1; step(2'd2, "R2");
    pkt_done = 1; step(2'd2, "R6");
    susp_rsp(1, 1, 0); step(2'd2, "R5");
    rxfifo_empty = 0; pkt_done = 1; step(2'd3, "R5");
    step(2'd3, "R5");
    step(2'd3, "R5");
    rxfifo_empty = 1; step(2'd0, "R5");
    // R7 fresh read, R8 end
    xfer_start = 1; step(2'd2, "R7");
    pkt_done = 1; step(2'd2, "R7");
    xfer_end = 1; step(2'd0, "R8");
    // R4 software abort during write after suspend ack
    dir_rd = 0; xfer_start = 1; step(2'd1, "R2");
    susp_rsp(1, 1, 0); step(2'd1, "R4");
    dp_en = 0; step(2'd0, "R4");
    step(2'd0, "R4");
    // R4 abort from receive-wait
    dp_en = 1; dir_rd = 1; xfer_start = 1; step(2'd2, "R2");
    susp_rsp(1, 1, 0); pkt_done = 1; rxfifo_empty = 0; step(2'd3, "R5");
    dp_en = 0; step(2'd0, "R4");
    rxfifo_empty = 1; dp_en = 1;
    // R4 abort from plain receive
    xfer_start = 1; step(2'd2, "R2");
    dp_en = 0; step(2'd0, "R4");
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule